// File: doc/BRIEF.md
# Multicast Group Address Hash Filter

This block decides whether a received frame addressed to a group (multicast) destination should be kept. The six destination address bytes arrive one per clock. While they arrive, a CRC-32 is accumulated over them. One cycle after the sixth byte, the top eight bits of the CRC form a hash index into a 256-bit table. The filter then reports whether the frame is accepted.

The table is stored as eight 32-bit registers. Software reads and writes these registers directly. The same byte stream can also carry a set or clear command instead of a lookup. Such a command turns the table entry selected by that address on or off, which lets a control path add or remove group addresses without computing the hash itself. The broadcast address is always accepted. A destination whose group bit is zero is never accepted by this filter.

Top module: `mhf_group_filter`

## Requirements
- R1: After a synchronous active-low reset, all eight table registers read 0 and `result_valid` and `accept` are 0.
- R2: `hash_index` is bits [31:24] of a CRC-32. The CRC uses polynomial 0x04C11DB7, starts from all ones and has no final inversion. It runs over the address bytes in arrival order, with each byte fed least significant bit first.
- R3: For a lookup, `result_valid` is high for exactly the one cycle that follows the clock edge taking the sixth byte. For a set or clear command it stays low.
- R4: Index bits [7:5] select a table register. Index bits [4:0] = n select bit 31-n of that register.
- R5: A set command (`cmd_op` 2'b01, sampled with the first byte) makes the indexed table bit 1 and leaves every other bit unchanged. The change takes effect at the edge that ends the result cycle.
- R6: A clear command (`cmd_op` 2'b10) makes the indexed table bit 0 and leaves every other bit unchanged.
- R7: For a lookup (`cmd_op` 2'b00, or the spare code 2'b11), `accept` is 1 when the group bit is set and the indexed table bit is 1. The group bit is bit 0 of the first byte.
- R8: The all-ones broadcast address is accepted whatever the table holds.
- R9: An address whose group bit is 0 is never accepted, even when its indexed table bit is 1.
- R10: A software write replaces the selected register at the next edge, and `sw_rdata` shows the register chosen by `sw_sel`. If a set or clear command lands on the same register at the same edge, the software write wins.
- R11: The first byte of a new address may arrive in the result cycle of the previous one. Both results are then correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | An address byte is present this cycle |
| byte_data | input | 8 | Address byte, first byte of the address first |
| cmd_op | input | 2 | 00 lookup, 01 set, 10 clear, 11 lookup; sampled with the first byte |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 3 | Table register select for read and write |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Contents of the selected table register |
| result_valid | output | 1 | Lookup result present this cycle |
| accept | output | 1 | Frame accepted by the group filter |
| hash_index | output | 8 | Hash index of the last address |

## Verification
The assertions assume that addresses arrive as whole groups of six valid bytes, so that a result never overlaps the middle of another address. They also assume `cmd_op` is stable while the first byte is presented. The bench tasks always drive six consecutive valid bytes with a constant command, idle or start a new address only at group boundaries, and change inputs only on the falling clock edge. The same-edge collision between a software write and a table command is produced on purpose and only at the edge where R10 defines the result.

// File: rtl/mhf_pkg.sv
// Package: shared command encoding for the multicast hash filter.
// Assumes: commands are sampled together with the first address byte.
package mhf_pkg;
    typedef enum logic [1:0] {
        MHF_LOOKUP = 2'b00,
        MHF_SET    = 2'b01,
        MHF_CLEAR  = 2'b10,
        MHF_SPARE  = 2'b11
    } mhf_op_e;
endpackage

// File: rtl/mhf_crc_engine.sv
// Module: byte-serial CRC over one destination address.
// Assumes: exactly ADDR_BYTES valid bytes per address; a new address may
// start in the cycle right after the last byte. Also captures the group
// bit of the first byte and whether every byte was all ones.
module mhf_crc_engine #(
    parameter int          ADDR_BYTES = 6,
    parameter int          CRC_W      = 32,
    parameter logic [31:0] CRC_POLY   = 32'h04C11DB7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    output logic             first_byte,
    output logic [CRC_W-1:0] crc_q,
    output logic             done_q,
    output logic             group_q,
    output logic             bcast_q
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CRC_W-1:0] INIT = {CRC_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_base;

    // One byte of CRC, least significant data bit first, shifting MSB out.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[CRC_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY[CRC_W-1:0];
            else                   r = r << 1;
        end
        return r;
    endfunction

    assign first_byte = byte_valid && (cnt_q == '0);
    assign crc_base   = (cnt_q == '0) ? INIT : crc_q;

    // Byte counter, CRC accumulation, address flags and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            crc_q   <= INIT;
            done_q  <= 1'b0;
            group_q <= 1'b0;
            bcast_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (byte_valid) begin
                crc_q <= crc_step(crc_base, byte_data);
                if (cnt_q == '0) begin
                    group_q <= byte_data[0];
                    bcast_q <= (byte_data == 8'hFF);
                end else begin
                    bcast_q <= bcast_q && (byte_data == 8'hFF);
                end
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R3
    done_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/mhf_hash_table.sv
// Module: group hash table held as NUM_REGS registers of REG_W bits.
// Assumes: REG_W is a power of two. Index bit position n maps to register
// bit REG_W-1-n. A software write wins over a same-edge table update.
module mhf_hash_table #(
    parameter int IDX_W = 8,
    parameter int REG_W = 32,
    localparam int POS_W = $clog2(REG_W),
    localparam int SEL_W = IDX_W - POS_W,
    localparam int NREGS = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [SEL_W-1:0] sw_sel,
    input  logic [REG_W-1:0] sw_wdata,
    output logic [REG_W-1:0] sw_rdata,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_en,
    input  logic             upd_set,
    output logic             lk_bit
);
    logic [REG_W-1:0] tbl_q [NREGS];
    logic [SEL_W-1:0] row;
    logic [POS_W-1:0] pos;

    assign row      = idx[IDX_W-1 -: SEL_W];
    assign pos      = ~idx[POS_W-1:0];
    assign lk_bit   = tbl_q[row][pos];
    assign sw_rdata = tbl_q[sw_sel];

    for (genvar g = 0; g < NREGS; g++) begin : g_row
        // Per-register update: software write first, then bit set/clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[g] <= '0;
            end else if (sw_we && sw_sel == SEL_W'(g)) begin
                tbl_q[g] <= sw_wdata;
            end else if (upd_en && row == SEL_W'(g)) begin
                tbl_q[g][pos] <= upd_set;
            end
        end
    end

    // R10
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> tbl_q[$past(sw_sel)] == $past(sw_wdata));
    // R5
    set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_set && !(sw_we && sw_sel == row))
        |=> tbl_q[$past(row)][$past(pos)]);
    // R6
    clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_set && !(sw_we && sw_sel == row))
        |=> !tbl_q[$past(row)][$past(pos)]);
endmodule

// File: rtl/mhf_group_filter.sv
// Module: top of the multicast hash filter. Hashes each six-byte address,
// then either looks up the table (accept decision) or sets/clears the entry.
// Assumes: the command is sampled with the first byte of each address.
module mhf_group_filter
    import mhf_pkg::*;
#(
    parameter int          ADDR_BYTES = 6,
    parameter int          IDX_W      = 8,
    parameter int          REG_W      = 32,
    parameter int          CRC_W      = 32,
    parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
    localparam int         SEL_W      = IDX_W - $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic [1:0]       cmd_op,
    input  logic             sw_we,
    input  logic [SEL_W-1:0] sw_sel,
    input  logic [REG_W-1:0] sw_wdata,
    output logic [REG_W-1:0] sw_rdata,
    output logic             result_valid,
    output logic             accept,
    output logic [IDX_W-1:0] hash_index
);
    logic             first_byte, done_q, group_q, bcast_q, lk_bit;
    logic [CRC_W-1:0] crc_q;
    mhf_op_e          op_q;
    logic             is_upd;

    // Latch the command that travels with the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n)          op_q <= MHF_LOOKUP;
        else if (first_byte) op_q <= mhf_op_e'(cmd_op);
    end

    mhf_crc_engine #(
        .ADDR_BYTES(ADDR_BYTES), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
    ) u_crc (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .first_byte(first_byte), .crc_q(crc_q), .done_q(done_q),
        .group_q(group_q), .bcast_q(bcast_q)
    );

    assign hash_index   = crc_q[CRC_W-1 -: IDX_W];
    assign is_upd       = (op_q == MHF_SET) || (op_q == MHF_CLEAR);
    assign result_valid = done_q && !is_upd;
    assign accept       = result_valid && group_q && (bcast_q || lk_bit);

    mhf_hash_table #(.IDX_W(IDX_W), .REG_W(REG_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .idx(hash_index),
        .upd_en(done_q && is_upd), .upd_set(op_q == MHF_SET), .lk_bit(lk_bit)
    );

    // R3
    result_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(byte_valid));
endmodule

// File: tb/tb_mhf_group_filter.sv
module tb_mhf_group_filter;
    logic        clk = 0, rst_n = 0;
    logic        byte_valid = 0;
    logic [7:0]  byte_data = 0;
    logic [1:0]  cmd_op = 0;
    logic        sw_we = 0;
    logic [2:0]  sw_sel = 0;
    logic [31:0] sw_wdata = 0;
    logic [31:0] sw_rdata;
    logic        result_valid, accept;
    logic [7:0]  hash_index;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [31:0] mdl [8];

    always #5 clk = ~clk;

    mhf_group_filter dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reflected CRC, then reversed top byte: independent form of R2.
    function automatic logic [7:0] exp_idx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        logic [7:0] o;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = a[47-8*k -: 8];
            for (int i = 0; i < 8; i++)
                r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        for (int i = 0; i < 8; i++) o[i] = r[7-i];
        return o;
    endfunction

    function automatic bit exp_acc(input logic [47:0] a);
        logic [7:0] x = exp_idx(a);
        if (a == 48'hFFFFFFFFFFFF) return 1;
        return a[40] && mdl[x[7:5]][31 - x[4:0]];
    endfunction

    function automatic void mdl_upd(input logic [1:0] op, input logic [47:0] a);
        logic [7:0] x = exp_idx(a);
        if (op == 2'b01) mdl[x[7:5]][31 - x[4:0]] = 1'b1;
        if (op == 2'b10) mdl[x[7:5]][31 - x[4:0]] = 1'b0;
    endfunction

    task automatic drive6(input logic [1:0] op, input logic [47:0] a);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            byte_valid = 1; byte_data = a[47-8*k -: 8]; cmd_op = op;
        end
    endtask

    // Check the result cycle (current negedge) for one address.
    task automatic check_result(input logic [1:0] op, input logic [47:0] a,
                                input string tag);
        #1;
        if (op == 2'b01 || op == 2'b10) begin
            chk(result_valid == 0, {tag, " R3 no result on command"}, result_valid, 0);
        end else begin
            chk(result_valid == 1, {tag, " R3 result_valid"}, result_valid, 1);
            chk(hash_index == exp_idx(a), {tag, " R2 hash_index"}, hash_index, exp_idx(a));
            chk(accept == exp_acc(a), {tag, " R7 accept"}, accept, exp_acc(a));
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [47:0] a, input string tag);
        drive6(op, a);
        @(negedge clk);
        byte_valid = 0;
        check_result(op, a, tag);
        mdl_upd(op, a);
        @(negedge clk);
        #1;
        chk(result_valid == 0, {tag, " R3 single pulse"}, result_valid, 0);
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < 8; r++) begin
            sw_sel = 3'(r);
            #1;
            chk(sw_rdata == mdl[r], tag, sw_rdata, mdl[r]);
        end
    endtask

    task automatic sw_write(input int r, input logic [31:0] v);
        @(negedge clk);
        sw_we = 1; sw_sel = 3'(r); sw_wdata = v;
        @(negedge clk);
        sw_we = 0;
        mdl[r] = v;
    endtask

    task automatic t_reset();
        for (int r = 0; r < 8; r++) mdl[r] = 0;
        #1;
        chk(result_valid == 0 && accept == 0, "R1 outputs", {result_valid, accept}, 0);
        check_regs("R1 table zero");
    endtask

    task automatic t_set_lookup();
        logic [47:0] a = 48'h01005E000001;
        logic [7:0] x = exp_idx(a);
        run_cmd(2'b00, a, "empty");
        run_cmd(2'b01, a, "set");
        check_regs("R4 R5 set mapping");
        chk(mdl[x[7:5]] == (32'h1 << (31 - x[4:0])), "R4 bit position",
            mdl[x[7:5]], 32'h1 << (31 - x[4:0]));
        run_cmd(2'b00, a, "hit");
        chk(exp_acc(a) == 1, "R7 expected hit", exp_acc(a), 1);
        run_cmd(2'b11, a, "spare op lookup");
        run_cmd(2'b00, 48'h01005E7F1234, "other group");
        run_cmd(2'b01, 48'h33330000ABCD, "set second");
        run_cmd(2'b00, 48'h33330000ABCD, "hit second");
        check_regs("R5 others kept");
    endtask

    task automatic t_individual();
        logic [47:0] a = 48'h00112233AA55;
        run_cmd(2'b01, a, "set individual");
        run_cmd(2'b00, a, "R9 individual");
        #1;
        chk(exp_acc(a) == 0, "R9 model", exp_acc(a), 0);
    endtask

    task automatic t_broadcast();
        for (int r = 0; r < 8; r++) sw_write(r, 32'h0);
        check_regs("R10 write zero");
        run_cmd(2'b00, 48'hFFFFFFFFFFFF, "R8 broadcast");
        run_cmd(2'b00, 48'hFFFFFFFFFFFE, "R8 near broadcast");
    endtask

    task automatic t_clear();
        logic [47:0] a = 48'h01005E000001;
        for (int r = 0; r < 8; r++) sw_write(r, 32'hFFFFFFFF);
        run_cmd(2'b00, a, "all ones hit");
        run_cmd(2'b10, a, "clear");
        check_regs("R6 clear one bit");
        run_cmd(2'b00, a, "R6 after clear");
    endtask

    task automatic t_collision();
        logic [47:0] a = 48'h01005E0A0B0C;
        logic [7:0] x = exp_idx(a);
        sw_write(x[7:5], 32'h0);
        drive6(2'b01, a);
        @(negedge clk);
        byte_valid = 0;
        sw_we = 1; sw_sel = x[7:5]; sw_wdata = 32'h5A5A0000;
        @(negedge clk);
        sw_we = 0;
        mdl[x[7:5]] = 32'h5A5A0000;
        #1;
        chk(sw_rdata == 32'h5A5A0000, "R10 write wins", sw_rdata, 32'h5A5A0000);
    endtask

    task automatic t_back_to_back();
        logic [47:0] a = 48'hFFFFFFFFFFFF, b = 48'h01005E123456;
        drive6(2'b00, a);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            byte_valid = 1; byte_data = b[47-8*k -: 8]; cmd_op = 2'b00;
            if (k == 0) check_result(2'b00, a, "R11 first");
            if (k == 1) begin
                #1;
                chk(result_valid == 0, "R11 gap", result_valid, 0);
            end
        end
        @(negedge clk);
        byte_valid = 0;
        check_result(2'b00, b, "R11 second");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_set_lookup();
        t_individual();
        t_broadcast();
        t_clear();
        t_collision();
        t_back_to_back();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule